// File: doc/BRIEF.md
# Rational-Ratio Rate Pulse Generator

This block derives a low-rate event stream whose long-term average rate is an exact rational fraction of its input clock. With the default settings it turns a 10 MHz clock into 32768 events per second. The ratio 32768/10,000,000 shares a factor of 128, so the block works with the reduced fraction 256/78125. A 17-bit remainder register falls by a fixed step on every clock. When the subtraction would go below zero, the borrow out of the subtractor marks an event and the modulus is folded back in. No magnitude comparator is needed.

Each event is a single-clock-wide pulse. Event spacing alternates between the two integers on either side of the exact ratio. The error therefore stays within one input clock and appears as periodic spurs, not as random jitter. A build-time mode doubles the step and adds a toggle stage. That stage turns the doubled event stream into a square wave at the target rate. The whole pattern repeats every 78125 input clocks.

Top module: `rate_pulse_gen`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it is released, `pulse_o` and `square_o` are 0. The first event then follows the same schedule as after power-up.
- R2: Let S be the step: 256 in pulse mode and 512 in square mode. Let D be the modulus, 78125. Number the rising edges after reset release k = 1, 2, and so on. After edge k, `pulse_o` is 1 exactly when floor(k·S/D) is greater than floor((k-1)·S/D).
- R3: `pulse_o` is never high on two consecutive clocks.
- R4: Consecutive pulses are 305 or 306 clocks apart in pulse mode, and 152 or 153 clocks apart in square mode.
- R5: Every window of 78125 clocks that starts at reset release holds exactly 256 pulses in pulse mode and exactly 512 in square mode. In square mode, `square_o` is 0 at the end of each such window.
- R6: In square mode, after edge k `square_o` equals floor(k·S/D) mod 2. It changes on exactly those edges on which an event occurs.
- R7: In pulse mode, `square_o` is held at 0.
- R8: The internal remainder always stays within 0 to D-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_o | output | 1 | One-clock event pulse at the averaged rate |
| square_o | output | 1 | Square wave at the target rate (square mode), else 0 |

## Verification
The hardest conditions to reach are the boundaries of the repeat window. The pulse count is exact only over a full 78125-clock period. The alternation between the short and long gap is visible only across hundreds of events. The stimulus therefore runs both build variants side by side for two complete periods plus a margin. It compares every cycle against an arithmetic floor model and counts the pulses at each window end. The run stops at a point where the square output is high. It then applies reset, so the restart from a non-idle level is checked as well.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
    typedef enum logic {
        OUT_PULSE  = 1'b0,
        OUT_SQUARE = 1'b1
    } out_mode_e;

    localparam int unsigned DEF_BASE_STEP = 256;
    localparam int unsigned DEF_MODULUS   = 78125;
endpackage

// File: rtl/rpg_accum.sv
module rpg_accum #(
    parameter int unsigned STEP    = 256,
    parameter int unsigned MODULUS = 78125
) (
    input  logic clk,
    input  logic rst_n,
    output logic event_o,
    output logic pulse_o
);
    localparam int unsigned ACC_W   = $clog2(MODULUS + 1);
    localparam int unsigned DIFF_W  = ACC_W + 1;
    localparam int unsigned MIN_GAP = MODULUS / STEP;

    typedef struct packed {
        logic [ACC_W-1:0] rem;
        logic             pulse;
    } acc_state_t;

    acc_state_t        st_d, st_q;
    logic [DIFF_W-1:0] diff;
    logic [DIFF_W-1:0] wrapped;
    logic              borrow;

    // Subtract the step; the extra top bit is the borrow that marks an event.
    always_comb begin
        diff    = {1'b0, st_q.rem} - DIFF_W'(STEP);
        borrow  = diff[DIFF_W-1];
        wrapped = diff + DIFF_W'(MODULUS);
        st_d.rem   = borrow ? wrapped[ACC_W-1:0] : diff[ACC_W-1:0];
        st_d.pulse = borrow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rem   <= ACC_W'(MODULUS - 1);
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign event_o = borrow;
    assign pulse_o = st_q.pulse;

    // Spacing tracker for the gap check only.
    logic [ACC_W-1:0] gap_q;
    logic             seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (borrow) begin
            gap_q  <= ACC_W'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + ACC_W'(1);
        end
    end

    assert_remainder_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rem <= ACC_W'(MODULUS - 1));

    assert_single_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);

    assert_event_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (borrow && seen_q) |-> (gap_q == ACC_W'(MIN_GAP) || gap_q == ACC_W'(MIN_GAP + 1)));
endmodule

// File: rtl/rpg_toggle.sv
module rpg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv_i,
    output logic level_o
);
    typedef struct packed {
        logic level;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d.level = st_q.level ^ adv_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.level <= 1'b0;
        else        st_q       <= st_d;
    end

    assign level_o = st_q.level;

    assert_toggle_on_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (level_o != $past(level_o)));

    assert_hold_without_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(level_o));
endmodule

// File: rtl/rate_pulse_gen.sv
module rate_pulse_gen #(
    parameter int unsigned       BASE_STEP = rpg_pkg::DEF_BASE_STEP,
    parameter int unsigned       MODULUS   = rpg_pkg::DEF_MODULUS,
    parameter rpg_pkg::out_mode_e MODE     = rpg_pkg::OUT_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse_o,
    output logic square_o
);
    localparam int unsigned STEP = (MODE == rpg_pkg::OUT_SQUARE) ? 2 * BASE_STEP : BASE_STEP;

    logic ev;

    rpg_accum #(
        .STEP    (STEP),
        .MODULUS (MODULUS)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_o (ev),
        .pulse_o (pulse_o)
    );

    generate
        if (MODE == rpg_pkg::OUT_SQUARE) begin : g_square
            rpg_toggle u_toggle (
                .clk     (clk),
                .rst_n   (rst_n),
                .adv_i   (ev),
                .level_o (square_o)
            );
        end else begin : g_pulse
            assign square_o = 1'b0;

            assert_square_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ev |=> !square_o);
        end
    endgenerate
endmodule

// File: tb/rate_pulse_gen_tb.sv
`timescale 1ns/1ps
module rate_pulse_gen_tb;
    localparam longint D      = 78125;
    localparam longint SP     = 256;
    localparam longint SS     = 512;
    localparam int     RUN_A  = 156410;
    localparam int     RUN_B  = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p_pulse, p_square, s_pulse, s_square;

    always #2.5 clk = ~clk;

    rate_pulse_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_o(p_pulse), .square_o(p_square));

    rate_pulse_gen #(.MODE(rpg_pkg::OUT_SQUARE)) u_dut_sq (
        .clk(clk), .rst_n(rst_n), .pulse_o(s_pulse), .square_o(s_square));

    typedef struct {
        int   step;
        logic p_pulse;
        logic s_pulse;
        logic s_level;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mon_en = 1'b0;
    bit   done = 1'b0;

    int last_p, last_s, win_p, win_s;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic longint events_upto(input longint k, input longint s);
        return (k * s) / D;
    endfunction

    // Driver: push the expected outputs for steps 1..n.
    task automatic push_expected(input int n);
        for (int k = 1; k <= n; k++) begin
            exp_t e;
            e.step    = k;
            e.p_pulse = (events_upto(k, SP) != events_upto(k - 1, SP));
            e.s_pulse = (events_upto(k, SS) != events_upto(k - 1, SS));
            e.s_level = events_upto(k, SS) % 2 == 1;
            exp_q.push_back(e);
        end
    endtask

    // Monitor: pop one expected item per clock and compare.
    always @(posedge clk) begin
        if (mon_en && exp_q.size() > 0) begin
            exp_t e;
            #1;
            e = exp_q.pop_front();
            check(p_pulse == e.p_pulse, "R2 pulse mode", p_pulse, e.p_pulse);
            check(s_pulse == e.s_pulse, "R2 square mode pulse", s_pulse, e.s_pulse);
            check(s_square == e.s_level, "R6 square level", s_square, e.s_level);
            check(p_square == 1'b0, "R7 square idle in pulse mode", p_square, 0);
            if (p_pulse) begin
                if (last_p > 0)
                    check((e.step - last_p) == 305 || (e.step - last_p) == 306,
                          "R4 pulse gap", e.step - last_p, 305);
                last_p = e.step;
                win_p++;
            end
            if (s_pulse) begin
                if (last_s > 0)
                    check((e.step - last_s) == 152 || (e.step - last_s) == 153,
                          "R4 square gap", e.step - last_s, 152);
                last_s = e.step;
                win_s++;
            end
            if (e.step % D == 0) begin
                check(win_p == 256, "R5 pulse window count", win_p, 256);
                check(win_s == 512, "R5 square window count", win_s, 512);
                check(s_square == 1'b0, "R5 square low at window end", s_square, 0);
                win_p = 0;
                win_s = 0;
            end
        end
    end

    task automatic run_phase(input int n);
        last_p = 0; last_s = 0; win_p = 0; win_s = 0;
        push_expected(n);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_en = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic check_reset_outputs();
        check(p_pulse == 1'b0 && s_pulse == 1'b0, "R1 pulses low in reset", p_pulse | s_pulse, 0);
        check(s_square == 1'b0 && p_square == 1'b0, "R1 squares low in reset", s_square | p_square, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_outputs();
        run_phase(RUN_A);
        // Square level is high here; reset must clear it.
        check(s_square == 1'b1, "R6 level before mid-run reset", s_square, 1);
        rst_n = 1'b0;
        #1;
        check_reset_outputs();
        repeat (2) @(negedge clk);
        check_reset_outputs();
        run_phase(RUN_B);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                #(5.0 * 170000);
                n_fail++;
                n_chk++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule